// File: doc/BRIEF.md
# Bus Hold and Lock Controller

This block sits between the processor's bus-cycle sequencer and the external bus pins. It decides when the sequencer may launch a new bus cycle, counts how many launched cycles still wait for their final ready strobe, and grants an external bus-hold request only once the bus is quiet. While the grant is held, the bus pins float through a single tri-state enable and no new cycle may start.

Locked cycle sequences are tracked as a unit. The active-low lock output falls in the same clock that the first locked cycle is accepted. It rises in the clock after the final ready of the closing cycle, which is the one the sequencer tagged as last. A hold request arriving mid-sequence waits for the whole sequence. After a sequence ends, the next locked sequence is refused for exactly one clock, so the lock pin always shows an idle clock between them.

While reset is applied, no cycles exist. The grant then simply follows the hold request one clock later, so an external master can take the bus during reset.

Top module: `bus_hold_lock`

## Requirements
- R1: `holdAck` is high only when no cycle is outstanding. A cycle retires on a clock edge where `brdy` and `cycDone` are both high, and `brdy` alone does not retire it. With `holdReq` high, `holdAck` rises at the edge that retires the last outstanding cycle, or at the next edge if none is outstanding.
- R2: Once granted, `holdAck` stays high and `busOe` stays low (pins floated) for as long as `holdReq` is high. At the first edge that samples `holdReq` low, `holdAck` falls and `busOe` returns high.
- R3: `holdAck` never rises while `lockN` is low. A hold that is requested during a locked sequence is granted at the edge that ends the sequence.
- R4: While `rst` is high, each edge loads `holdAck` with `holdReq`. During reset, `startOk` is low, `lockN` is high and all tracking state clears.
- R5: `lockN` goes low in the same clock in which the first locked cycle of a sequence is accepted. A cycle is accepted when `cycStart` and `startOk` are both high, and `cycLock` high marks it as locked.
- R6: `lockN` returns high at the edge that retires the last outstanding cycle after the cycle tagged with `lockLast` has been accepted. It stays low through earlier retirements in the sequence.
- R7: In the single clock after a locked sequence ends, a locked start is refused and `lockN` stays high. An unlocked start is allowed in that clock, and a locked start is allowed in the clock after it.
- R8: `startOk` is low for every clock in which `holdAck` is high. Starts are allowed again in the clock after `holdReq` is released.
- R9: At most `MAX_OUT` cycles (default 2) are outstanding. `startOk` is low while that many are outstanding.
- R10: A locked sequence opens only when no cycle is outstanding. Inside a sequence, only locked starts are accepted. Once the `lockLast` cycle has been accepted, no start is accepted until the sequence ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| holdReq | input | 1 | External bus-hold request |
| cycStart | input | 1 | Sequencer wants to launch a cycle this clock |
| cycLock | input | 1 | The requested cycle is locked |
| lockLast | input | 1 | The requested locked cycle closes its sequence |
| brdy | input | 1 | Bus ready strobe |
| cycDone | input | 1 | Qualifies `brdy` as the final ready of the oldest cycle |
| startOk | output | 1 | Launch permitted this clock |
| holdAck | output | 1 | Hold acknowledge |
| busOe | output | 1 | Bus pin output enable (low = floated) |
| lockN | output | 1 | Bus lock, active low |

## Verification
The bench sweeps 0, 1 and 2 outstanding cycles under a pending hold and counts the clock in which the grant appears. A design that granted early would float the pins under a live cycle, and one that treated a bare `brdy` as a retirement would grant one cycle too soon. Locked sequences are exercised with a hold pending, with a tagged last cycle that is still in flight, and back to back. A design that acknowledged hold inside a sequence, released the lock on the first ready, or let a new sequence start in the clock right after the previous one ended would each miss an exact-clock check. Reset is applied with hold both asserted and released to confirm that the grant follows the request.

// File: rtl/bhl_pkg.sv
package bhl_pkg;

  // Strobes from control to datapath, all valid in the current clock
  typedef struct packed {
    logic accept;     // a cycle is launched at this edge
    logic lockOpen;   // launched cycle opens a locked sequence
    logic markLast;   // launched cycle closes its locked sequence
    logic retire;     // oldest outstanding cycle completes at this edge
    logic lockClose;  // locked sequence ends at this edge
  } bhlStrobe_t;

  // Registered status from datapath back to control
  typedef struct packed {
    logic cntZero;
    logic cntOne;
    logic cntFull;
    logic lockAct;
    logic closing;
    logic gap;
    logic ack;
  } bhlState_t;

endpackage

// File: rtl/bhl_ctrl.sv
module bhl_ctrl
  import bhl_pkg::*;
(
  input  logic       rst,
  input  logic       cycStart,
  input  logic       cycLock,
  input  logic       lockLast,
  input  logic       brdy,
  input  logic       cycDone,
  input  bhlState_t  st,
  output logic       startOk,
  output bhlStrobe_t stb
);

  logic lockGate;
  logic baseOk;

  // Rules for which kind of cycle may be launched in the current lock state
  always_comb begin
    if (st.lockAct) lockGate = cycLock;
    else            lockGate = !cycLock || (!st.gap && st.cntZero);
  end

  assign baseOk  = !rst && !st.ack && !st.cntFull && !st.closing;
  assign startOk = baseOk && lockGate;

  always_comb begin
    stb.accept    = cycStart && startOk;
    stb.lockOpen  = stb.accept && cycLock && !st.lockAct;
    stb.markLast  = stb.accept && cycLock && lockLast;
    stb.retire    = !rst && brdy && cycDone && !st.cntZero;
    stb.lockClose = stb.retire && st.closing && st.cntOne;
  end

endmodule

// File: rtl/bhl_dp.sv
module bhl_dp
  import bhl_pkg::*;
#(
  parameter int MAX_OUT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       holdReq,
  input  bhlStrobe_t stb,
  output bhlState_t  st,
  output logic       holdAck,
  output logic       busOe,
  output logic       lockN
);

  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ, cntNext;
  logic lockActQ, lockActNext;
  logic closingQ, closingNext;
  logic gapQ;
  logic ackQ, ackNext;

  always_comb begin
    cntNext = cntQ;
    if (stb.accept && !stb.retire)      cntNext = cntQ + CNT_ONE;
    else if (!stb.accept && stb.retire) cntNext = cntQ - CNT_ONE;
  end

  always_comb begin
    lockActNext = lockActQ;
    if (stb.lockClose)     lockActNext = 1'b0;
    else if (stb.lockOpen) lockActNext = 1'b1;
    closingNext = closingQ;
    if (stb.lockClose)     closingNext = 1'b0;
    else if (stb.markLast) closingNext = 1'b1;
  end

  // Grant once the next state is quiet; keep it while the request stays
  assign ackNext = holdReq && (ackQ || (cntNext == '0 && !lockActNext));

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ     <= '0;
      lockActQ <= 1'b0;
      closingQ <= 1'b0;
      gapQ     <= 1'b0;
      ackQ     <= holdReq;
    end else begin
      cntQ     <= cntNext;
      lockActQ <= lockActNext;
      closingQ <= closingNext;
      gapQ     <= stb.lockClose;
      ackQ     <= ackNext;
    end
  end

  always_comb begin
    st.cntZero = (cntQ == '0);
    st.cntOne  = (cntQ == CNT_ONE);
    st.cntFull = (cntQ >= CNT_MAX);
    st.lockAct = lockActQ;
    st.closing = closingQ;
    st.gap     = gapQ;
    st.ack     = ackQ;
  end

  assign holdAck = ackQ;
  assign busOe   = !ackQ;
  assign lockN   = !(lockActQ || stb.lockOpen);

endmodule

// File: rtl/bus_hold_lock.sv
module bus_hold_lock
  import bhl_pkg::*;
#(
  parameter int MAX_OUT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic holdReq,
  input  logic cycStart,
  input  logic cycLock,
  input  logic lockLast,
  input  logic brdy,
  input  logic cycDone,
  output logic startOk,
  output logic holdAck,
  output logic busOe,
  output logic lockN
);

  bhlStrobe_t stb;
  bhlState_t  stat;

  bhl_ctrl ctrl_i (
    .rst      (rst),
    .cycStart (cycStart),
    .cycLock  (cycLock),
    .lockLast (lockLast),
    .brdy     (brdy),
    .cycDone  (cycDone),
    .st       (stat),
    .startOk  (startOk),
    .stb      (stb)
  );

  bhl_dp #(.MAX_OUT(MAX_OUT)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .holdReq (holdReq),
    .stb     (stb),
    .st      (stat),
    .holdAck (holdAck),
    .busOe   (busOe),
    .lockN   (lockN)
  );

endmodule

// File: rtl/bhl_chk.sv
module bhl_chk (
  input logic clk,
  input logic rst,
  input logic holdReq,
  input logic holdAck,
  input logic busOe,
  input logic lockN,
  input logic startOk,
  input logic cycStart,
  input logic cycLock,
  input logic cntZero
);

  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
    holdAck |-> cntZero); // R1

  AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (holdReq && holdAck) |=> holdAck); // R2

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !holdReq |=> (!holdAck && busOe)); // R2

  AST_NO_ACK_LOCKED: assert property (@(posedge clk) disable iff (rst)
    holdAck |-> lockN); // R3

  AST_RESET_FOLLOW: assert property (@(posedge clk)
    rst |=> (holdAck == $past(holdReq))); // R4

  AST_LOCK_FIRST: assert property (@(posedge clk) disable iff (rst)
    (cycStart && startOk && cycLock) |-> !lockN); // R5

  AST_LOCK_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(lockN) |-> !(cycStart && cycLock && startOk)); // R7

  AST_NO_START_ACK: assert property (@(posedge clk) disable iff (rst)
    holdAck |-> !startOk); // R8

endmodule

bind bus_hold_lock bhl_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .holdReq  (holdReq),
  .holdAck  (holdAck),
  .busOe    (busOe),
  .lockN    (lockN),
  .startOk  (startOk),
  .cycStart (cycStart),
  .cycLock  (cycLock),
  .cntZero  (stat.cntZero)
);

// File: tb/bus_hold_lock_tb_top.sv
module bus_hold_lock_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic holdReq = 1'b0, cycStart = 1'b0, cycLock = 1'b0, lockLast = 1'b0;
  logic brdy = 1'b0, cycDone = 1'b0;
  logic startOk, holdAck, busOe, lockN;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  bus_hold_lock #(.MAX_OUT(2)) dut_i (
    .clk(clk), .rst(rst), .holdReq(holdReq), .cycStart(cycStart),
    .cycLock(cycLock), .lockLast(lockLast), .brdy(brdy), .cycDone(cycDone),
    .startOk(startOk), .holdAck(holdAck), .busOe(busOe), .lockN(lockN)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic retireOne();
    brdy = 1'b1; cycDone = 1'b1;
    tick();
    brdy = 1'b0; cycDone = 1'b0;
  endtask

  initial begin
    #4000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R4: reset state and hold grant during reset
    tick();
    chk("R4 ack in reset", holdAck, 1'b0);
    chk("R4 startOk in reset", startOk, 1'b0);
    chk("R4 lockN in reset", lockN, 1'b1);
    chk("R4 busOe in reset", busOe, 1'b1);
    holdReq = 1'b1;
    tick();
    chk("R4 ack follows request", holdAck, 1'b1);
    chk("R2 pins floated", busOe, 1'b0);
    holdReq = 1'b0;
    tick();
    chk("R4 ack follows release", holdAck, 1'b0);
    rst = 1'b0;
    tick();

    // R1 R2 R8 R9: sweep of outstanding count under a pending hold
    for (int n = 0; n <= 2; n++) begin
      for (int k = 0; k < n; k++) begin
        cycStart = 1'b1; cycLock = 1'b0;
        #1 chk("R9 start allowed below limit", startOk, 1'b1);
        tick();
      end
      cycStart = 1'b0;
      if (n == 2) begin
        cycStart = 1'b1;
        #1 chk("R9 start refused at limit", startOk, 1'b0);
        cycStart = 1'b0;
      end
      holdReq = 1'b1;
      tick();
      chk("R1 grant vs outstanding", holdAck, n == 0);
      if (n == 2) begin
        brdy = 1'b1;
        tick();
        brdy = 1'b0;
        chk("R1 brdy alone retires nothing", holdAck, 1'b0);
      end
      for (int k = 0; k < n; k++) begin
        retireOne();
        chk("R1 grant at last retirement", holdAck, k == n - 1);
      end
      chk("R2 pins floated", busOe, 1'b0);
      cycStart = 1'b1;
      #1 chk("R8 no start while granted", startOk, 1'b0);
      cycStart = 1'b0;
      for (int k = 0; k < 3; k++) begin
        tick();
        chk("R2 grant held", holdAck, 1'b1);
      end
      holdReq = 1'b0;
      tick();
      chk("R2 grant released", holdAck, 1'b0);
      chk("R2 pins driven", busOe, 1'b1);
      chk("R8 starts resume", startOk, 1'b1);
    end

    // R5 R6 R3 R10: two-cycle locked sequence with a hold pending
    cycStart = 1'b1; cycLock = 1'b1; lockLast = 1'b0;
    #1 chk("R5 lock low with first locked start", lockN, 1'b0);
    tick();
    holdReq = 1'b1;
    cycLock = 1'b0;
    #1 chk("R10 unlocked start refused in sequence", startOk, 1'b0);
    cycLock = 1'b1; lockLast = 1'b1;
    #1 chk("R10 locked start allowed in sequence", startOk, 1'b1);
    tick();
    lockLast = 1'b0; cycStart = 1'b0;
    chk("R3 no grant during lock", holdAck, 1'b0);
    retireOne();
    chk("R6 lock held after first ready", lockN, 1'b0);
    chk("R3 no grant during lock", holdAck, 1'b0);
    retireOne();
    chk("R6 lock released after last ready", lockN, 1'b1);
    chk("R3 grant at sequence end", holdAck, 1'b1);
    holdReq = 1'b0;
    tick();
    chk("R2 grant released", holdAck, 1'b0);

    // R10 closing: single locked cycle tagged last, further starts refused
    cycStart = 1'b1; cycLock = 1'b1; lockLast = 1'b1;
    #1 chk("R5 lock low with single locked start", lockN, 1'b0);
    tick();
    cycLock = 1'b0; lockLast = 1'b0;
    #1 chk("R10 start refused after last tagged", startOk, 1'b0);
    cycStart = 1'b0;
    retireOne();
    chk("R6 lock released", lockN, 1'b1);

    // R7: idle clock between back-to-back sequences
    cycStart = 1'b1; cycLock = 1'b1; lockLast = 1'b1;
    #1 chk("R7 locked start refused in gap", startOk, 1'b0);
    chk("R7 lock stays high in gap", lockN, 1'b1);
    tick();
    #1 chk("R7 locked start allowed after gap", startOk, 1'b1);
    chk("R5 lock low for new sequence", lockN, 1'b0);
    tick();
    cycStart = 1'b0; cycLock = 1'b0; lockLast = 1'b0;
    retireOne();
    cycStart = 1'b1;
    #1 chk("R7 unlocked start allowed in gap", startOk, 1'b1);
    tick();
    cycLock = 1'b1;
    #1 chk("R10 lock needs idle bus", startOk, 1'b0);
    cycStart = 1'b0; cycLock = 1'b0;
    retireOne();

    // R4: reset mid-run with hold requested
    rst = 1'b1; holdReq = 1'b1;
    tick();
    chk("R4 ack follows request", holdAck, 1'b1);
    chk("R4 no start in reset", startOk, 1'b0);
    chk("R4 lock high in reset", lockN, 1'b1);
    rst = 1'b0; holdReq = 1'b0;
    tick();
    chk("R2 grant released after reset", holdAck, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule